// File: doc/BRIEF.md
# NAND Mode-Register Bus Bridge

This block links a 16-bit memory-mapped host bus to a raw NAND flash device with an 8-bit data path. Software first writes a byte-wide mode register. That register drives the flash latch pins directly: chip enable, command latch and address latch. It also switches media power on and off, and it decides whether a data write may go out to the device. Accesses to the data port then become NAND byte cycles. A 16-bit access becomes two flash bytes in sequence, low byte first. An 8-bit access becomes a single flash byte.

Every flash byte cycle has fixed timing. The data bus is driven for a set-up phase, then the write or read strobe is held low for a set number of clocks, then a hold phase follows. While these cycles run, the host bus is held with a ready/wait signal, and it is released for one clock once the last byte is done. A status register shows the ready/busy line of the device, so software can poll for the end of a program or erase.

Top module: `nand_mode_bridge`

## Requirements
- R1: Reset leaves the mode register at 0x00. Reset also leaves CE# high, CLE and ALE low, WE# and RE# high, the data bus undriven and media power off.
- R2: Mode bit 4 set drives CE# low, bit 0 drives CLE and bit 1 drives ALE. So 0x94 gives data cycles, 0x95 command cycles, 0x96 address cycles and 0x00 standby. A read of offset 0x04 returns the mode in bits 7:0 and zero above.
- R3: A mode write with bit 3 set loads bit 2 into media power, so 0x0C turns power on and 0x08 turns it off. A mode write with bit 3 clear leaves power unchanged.
- R4: A read of offset 0x05 returns 1 in bit 7 while the ready/busy input is low (busy) and 0 in bit 7 otherwise. All other bits read 0.
- R5: A 16-bit write to offset 0x00 issues two WE# cycles: first bits 7:0, then bits 15:8. Each WE# low pulse lasts STROBE_CLKS clocks.
- R6: An 8-bit write to offset 0x00 issues exactly one WE# cycle carrying bits 7:0. CLE and ALE hold their mode values for the whole strobe.
- R7: A 16-bit read of offset 0x00 issues two RE# cycles of STROBE_CLKS clocks each. The first byte returns in bits 7:0 and the second in bits 15:8. An 8-bit read issues one RE# cycle and returns zero in bits 15:8.
- R8: During a write, the data bus is driven for at least SETUP_CLKS clocks before WE# falls and for at least HOLD_CLKS clocks after it rises. WE# and RE# are never low together. A strobe is only ever low while CE# is low.
- R9: A data-port access that makes flash cycles holds ready low for n*(SETUP_CLKS+STROBE_CLKS+HOLD_CLKS) clocks after the clock in which it is first presented, where n is the number of bytes. Ready is then high for one clock. A register access is ready at once.
- R10: A data-port access with mode bit 4 clear completes at once with no strobe, and a read of it returns 0. A data-port write with mode bit 7 clear completes at once with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hb_sel | input | 1 | Host access request, held until ready |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| hb_addr | input | 3 | Register byte offset |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, valid while ready is high |
| hb_ready | output | 1 | Access completes in this clock |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_in | input | 8 | Flash data in |
| nf_rb_n | input | 1 | Flash ready/busy, low = busy |
| nf_pwr_en | output | 1 | Media power switch |

## Verification
The assertions assume that the host holds select, offset, direction, size and data steady from the clock an access is presented until the clock in which ready is high. They also assume that no mode write arrives while flash cycles are running. The chip-enable check depends on the second of these. The bench keeps to both rules: one task issues every access, holds all the bus signals until it sees ready, and drops select in that same clock. The flash model in the bench returns read bytes from an arithmetic sequence, and it changes them only after RE# has risen.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam logic [2:0] OFS_DATA = 3'h0;
  localparam logic [2:0] OFS_MODE = 3'h4;
  localparam logic [2:0] OFS_STAT = 3'h5;

  localparam int MB_CLE     = 0;
  localparam int MB_ALE     = 1;
  localparam int MB_PWR_VAL = 2;
  localparam int MB_PWR_CMD = 3;
  localparam int MB_CE      = 4;
  localparam int MB_WEN     = 7;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE,
    SQ_HOLD,
    SQ_DONE
  } sq_state_t;

  function automatic int cnt_width(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return $clog2(m + 1);
  endfunction

  function automatic int access_wait(int nbytes, int su, int st, int hd);
    return nbytes * (su + st + hd);
  endfunction

  function automatic logic power_next(logic cur, logic [7:0] wbyte);
    return wbyte[MB_PWR_CMD] ? wbyte[MB_PWR_VAL] : cur;
  endfunction

  function automatic logic [15:0] lane_insert(logic [15:0] acc, logic hi, logic [7:0] b);
    logic [15:0] r;
    r = acc;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

endpackage

// File: rtl/nbb_mode_regs.sv
module nbb_mode_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  output logic [7:0] mode,
  output logic       pwr_en,
  output logic       ce_n,
  output logic       cle,
  output logic       ale
);
  import nbb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= 8'h00;
      pwr_en <= 1'b0;
    end else if (wr_en) begin
      mode   <= wbyte;
      pwr_en <= power_next(pwr_en, wbyte);
    end
  end

  assign ce_n = ~mode[MB_CE];
  assign cle  = mode[MB_CLE];
  assign ale  = mode[MB_ALE];

  AST_PWR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wbyte[MB_PWR_CMD]) |=> $stable(pwr_en)); // R3
  AST_PWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wbyte[MB_PWR_CMD]) |=> (pwr_en == $past(wbyte[MB_PWR_VAL]))); // R3

endmodule

// File: rtl/nbb_cycle_seq.sv
module nbb_cycle_seq #(
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_rd,
  input  logic        go_two,
  input  logic [15:0] go_wdata,
  input  logic [7:0]  nf_dq_in,
  output logic        idle,
  output logic        done,
  output logic [15:0] rdata,
  output logic        we_n,
  output logic        re_n,
  output logic        dq_oe,
  output logic [7:0]  dq_out
);
  import nbb_pkg::*;

  localparam int CW = cnt_width(SETUP_CLKS, STROBE_CLKS, HOLD_CLKS);
  localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] ST_LAST = CW'(STROBE_CLKS - 1);
  localparam logic [CW-1:0] HD_LAST = CW'(HOLD_CLKS - 1);

  sq_state_t       state;
  logic [CW-1:0]   cnt;
  logic            idx;
  logic            two;
  logic            rd;
  logic [15:0]     wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      idx   <= 1'b0;
      two   <= 1'b0;
      rd    <= 1'b0;
      wbuf  <= '0;
      rdata <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (go) begin
          state <= SQ_SETUP;
          cnt   <= '0;
          idx   <= 1'b0;
          two   <= go_two;
          rd    <= go_rd;
          wbuf  <= go_wdata;
          rdata <= '0;
        end
        SQ_SETUP: if (cnt == SU_LAST) begin
          cnt   <= '0;
          state <= SQ_STROBE;
        end else cnt <= cnt + 1'b1;
        SQ_STROBE: if (cnt == ST_LAST) begin
          cnt   <= '0;
          state <= SQ_HOLD;
          if (rd) rdata <= lane_insert(rdata, idx, nf_dq_in);
        end else cnt <= cnt + 1'b1;
        SQ_HOLD: if (cnt == HD_LAST) begin
          cnt <= '0;
          if (two && !idx) begin
            idx   <= 1'b1;
            state <= SQ_SETUP;
          end else state <= SQ_DONE;
        end else cnt <= cnt + 1'b1;
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  logic active;
  assign active = (state == SQ_SETUP) || (state == SQ_STROBE) || (state == SQ_HOLD);
  assign idle   = (state == SQ_IDLE);
  assign done   = (state == SQ_DONE);
  assign dq_out = idx ? wbuf[15:8] : wbuf[7:0];
  assign dq_oe  = active && !rd;
  assign we_n   = !((state == SQ_STROBE) && !rd);
  assign re_n   = !((state == SQ_STROBE) && rd);

  // independent low-time counter for the strobe width check
  logic [CW:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_cnt <= '0;
    else if (!we_n || !re_n) lo_cnt <= lo_cnt + 1'b1;
    else lo_cnt <= '0;
  end

  AST_DQ_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(dq_oe)); // R8
  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R8
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) || $rose(re_n)) |-> (lo_cnt == (CW+1)'(STROBE_CLKS))); // R5

endmodule

// File: rtl/nbb_host_port.sv
module nbb_host_port (
  input  logic        hb_sel,
  input  logic        hb_wr,
  input  logic [2:0]  hb_addr,
  input  logic [7:0]  mode,
  input  logic        nf_rb_n,
  input  logic        seq_idle,
  input  logic        seq_done,
  input  logic [15:0] seq_rdata,
  output logic        hb_ready,
  output logic [15:0] hb_rdata,
  output logic        go,
  output logic        mode_wr
);
  import nbb_pkg::*;

  logic strobed;
  assign strobed  = (hb_addr == OFS_DATA) && mode[MB_CE] && (!hb_wr || mode[MB_WEN]);
  assign go       = hb_sel && strobed && seq_idle;
  assign hb_ready = hb_sel && (strobed ? seq_done : 1'b1);
  assign mode_wr  = hb_sel && hb_wr && (hb_addr == OFS_MODE);

  always_comb begin
    hb_rdata = '0;
    case (hb_addr)
      OFS_DATA: if (strobed) hb_rdata = seq_rdata;
      OFS_MODE: hb_rdata = {8'h00, mode};
      OFS_STAT: hb_rdata = {8'h00, !nf_rb_n, 7'b0};
      default:  hb_rdata = '0;
    endcase
  end

endmodule

// File: rtl/nand_mode_bridge.sv
module nand_mode_bridge #(
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hb_sel,
  input  logic        hb_wr,
  input  logic        hb_word,
  input  logic [2:0]  hb_addr,
  input  logic [15:0] hb_wdata,
  output logic [15:0] hb_rdata,
  output logic        hb_ready,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_out,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_in,
  input  logic        nf_rb_n,
  output logic        nf_pwr_en
);
  import nbb_pkg::*;

  logic [7:0]  mode;
  logic        mode_wr;
  logic        go;
  logic        seq_idle;
  logic        seq_done;
  logic [15:0] seq_rdata;

  nbb_mode_regs i_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mode_wr),
    .wbyte  (hb_wdata[7:0]),
    .mode   (mode),
    .pwr_en (nf_pwr_en),
    .ce_n   (nf_ce_n),
    .cle    (nf_cle),
    .ale    (nf_ale)
  );

  nbb_host_port i_port (
    .hb_sel    (hb_sel),
    .hb_wr     (hb_wr),
    .hb_addr   (hb_addr),
    .mode      (mode),
    .nf_rb_n   (nf_rb_n),
    .seq_idle  (seq_idle),
    .seq_done  (seq_done),
    .seq_rdata (seq_rdata),
    .hb_ready  (hb_ready),
    .hb_rdata  (hb_rdata),
    .go        (go),
    .mode_wr   (mode_wr)
  );

  nbb_cycle_seq #(
    .SETUP_CLKS  (SETUP_CLKS),
    .STROBE_CLKS (STROBE_CLKS),
    .HOLD_CLKS   (HOLD_CLKS)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .go_rd    (!hb_wr),
    .go_two   (hb_word),
    .go_wdata (hb_wdata),
    .nf_dq_in (nf_dq_in),
    .idle     (seq_idle),
    .done     (seq_done),
    .rdata    (seq_rdata),
    .we_n     (nf_we_n),
    .re_n     (nf_re_n),
    .dq_oe    (nf_dq_oe),
    .dq_out   (nf_dq_out)
  );

  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R8
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_sel && (hb_addr == OFS_DATA) && !seq_idle && !seq_done) |-> !hb_ready); // R9
  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_ready && hb_sel && (hb_addr == OFS_DATA) && seq_done) |=> !seq_done); // R9

endmodule

// File: tb/test_nand_mode_bridge.sv
`timescale 1ns/1ps
module test_nand_mode_bridge;
  localparam int SU = 1;
  localparam int ST = 3;
  localparam int HD = 1;
  localparam int PER_BYTE = SU + ST + HD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_sel = 0, hb_wr = 0, hb_word = 0;
  logic [2:0] hb_addr = 0;
  logic [15:0] hb_wdata = 0;
  logic [15:0] hb_rdata;
  logic hb_ready;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_pwr_en;
  logic [7:0] nf_dq_out;
  logic [7:0] nf_dq_in;
  logic nf_rb_n = 1'b1;

  always #2 clk = ~clk;

  nand_mode_bridge #(.SETUP_CLKS(SU), .STROBE_CLKS(ST), .HOLD_CLKS(HD)) i_nand_mode_bridge (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_word(hb_word),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ready(hb_ready),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
    .nf_rb_n(nf_rb_n), .nf_pwr_en(nf_pwr_en)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // flash model: read bytes from an arithmetic sequence, write strobes recorded
  int rd_ptr = 0;
  function automatic logic [7:0] rd_pat(int k);
    return 8'((k * 29 + 90) % 256);
  endfunction
  assign nf_dq_in = rd_pat(rd_ptr);

  int wev_cnt = 0, rev_cnt = 0;
  int wev_data[4], wev_cle[4], wev_ale[4], wev_w[4], wev_su[4], wev_hd[4];
  int rev_w[4];
  bit prev_we = 1, prev_re = 1, prev_oe = 0;
  int cur_w = 0, cur_rw = 0, cur_su = 0, cur_d = 0, cur_c = 0, cur_a = 0;

  always @(negedge clk) begin
    if (!nf_we_n) begin
      if (prev_we) begin cur_w = 1; cur_su = int'(prev_oe); end
      else cur_w++;
      cur_d = nf_dq_out; cur_c = nf_cle; cur_a = nf_ale;
    end else if (!prev_we && wev_cnt < 4) begin
      wev_data[wev_cnt] = cur_d; wev_cle[wev_cnt] = cur_c; wev_ale[wev_cnt] = cur_a;
      wev_w[wev_cnt] = cur_w; wev_su[wev_cnt] = cur_su; wev_hd[wev_cnt] = int'(nf_dq_oe);
      wev_cnt++;
    end
    if (!nf_re_n) begin
      if (prev_re) cur_rw = 1; else cur_rw++;
    end else if (!prev_re) begin
      if (rev_cnt < 4) rev_w[rev_cnt] = cur_rw;
      rev_cnt++;
      rd_ptr++;
    end
    prev_we = nf_we_n; prev_re = nf_re_n; prev_oe = nf_dq_oe;
  end

  task automatic access(input bit wr, input bit word, input logic [2:0] addr,
                        input logic [15:0] wd, output logic [15:0] rd, output int waits);
    @(negedge clk);
    wev_cnt = 0; rev_cnt = 0;
    hb_sel = 1; hb_wr = wr; hb_word = word; hb_addr = addr; hb_wdata = wd;
    waits = 0;
    rd = '0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hb_ready) begin rd = hb_rdata; break; end
      waits++;
    end
    hb_sel = 0; hb_wr = 0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    logic [15:0] r; int w;
    access(1, 0, 3'h4, {8'h00, m}, r, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r; int w; bit pwr_model; int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(nf_ce_n === 1 && nf_cle === 0 && nf_ale === 0, "R1 pins", {nf_ce_n, nf_cle, nf_ale}, 3'b100);
    check(nf_we_n === 1 && nf_re_n === 1 && nf_dq_oe === 0 && nf_pwr_en === 0, "R1 strobes",
          {nf_we_n, nf_re_n, nf_dq_oe, nf_pwr_en}, 4'b1100);
    rst_n = 1;
    access(0, 0, 3'h4, 16'h0, r, w);
    check(r == 16'h0000, "R1 mode after reset", r, 0);

    // R2/R3 exhaustive sweep of mode values
    pwr_model = 0;
    for (int m = 0; m < 256; m++) begin
      set_mode(8'(m));
      if ((m / 8) % 2 == 1) pwr_model = ((m / 4) % 2) == 1;
      check(nf_pwr_en == pwr_model, "R3 power", nf_pwr_en, pwr_model);
      check(nf_ce_n == !((m / 16) % 2) && nf_cle == (m % 2) && nf_ale == ((m / 2) % 2),
            "R2 pins", {nf_ce_n, nf_cle, nf_ale}, m);
      access(0, 1, 3'h4, 16'h0, r, w);
      check(r == 16'(m) && w == 0, "R2 readback", r, m);
    end
    set_mode(8'h0C);
    check(nf_pwr_en == 1, "R3 on", nf_pwr_en, 1);
    set_mode(8'h94);
    check(nf_pwr_en == 1 && nf_ce_n == 0 && nf_cle == 0 && nf_ale == 0, "R2 data mode", nf_pwr_en, 1);

    // R4 status
    nf_rb_n = 0;
    access(0, 0, 3'h5, 0, r, w);
    check(r == 16'h0080, "R4 busy", r, 16'h0080);
    nf_rb_n = 1;
    access(0, 0, 3'h5, 0, r, w);
    check(r == 16'h0000, "R4 ready", r, 0);

    // R5/R8/R9 word writes
    for (int v = 0; v < 64; v++) begin
      logic [15:0] d;
      d = 16'((v * 1027 + 4660) % 65536);
      access(1, 1, 3'h0, d, r, w);
      check(wev_cnt == 2, "R5 two cycles", wev_cnt, 2);
      check(wev_data[0] == d % 256 && wev_data[1] == d / 256, "R5 byte order",
            wev_data[0] + 256 * wev_data[1], d);
      check(wev_w[0] == ST && wev_w[1] == ST, "R5 width", wev_w[0], ST);
      check(wev_su[0] == 1 && wev_su[1] == 1 && wev_hd[0] == 1 && wev_hd[1] == 1, "R8 setup/hold",
            wev_su[0] + wev_hd[1], 2);
      check(w == 2 * PER_BYTE, "R9 word wait", w, 2 * PER_BYTE);
    end

    // R6 byte writes in command, address and data modes
    for (int k = 0; k < 3; k++) begin
      set_mode(8'(148 + k));
      for (int v = 0; v < 8; v++) begin
        access(1, 0, 3'h0, 16'(v * 4113 + 7), r, w);
        check(wev_cnt == 1 && wev_data[0] == (v * 4113 + 7) % 256, "R6 single byte", wev_data[0],
              (v * 4113 + 7) % 256);
        check(wev_cle[0] == k % 2 && wev_ale[0] == k / 2, "R6 latch held", wev_cle[0] + 2 * wev_ale[0], k);
        check(w == PER_BYTE, "R9 byte wait", w, PER_BYTE);
      end
    end

    // R7 reads
    set_mode(8'h94);
    for (int v = 0; v < 32; v++) begin
      p0 = rd_ptr;
      access(0, 1, 3'h0, 0, r, w);
      check(r == {rd_pat(p0 + 1), rd_pat(p0)}, "R7 word read", r, {rd_pat(p0 + 1), rd_pat(p0)});
      check(rev_cnt == 2 && rev_w[0] == ST && rev_w[1] == ST, "R7 read strobes", rev_cnt, 2);
      check(w == 2 * PER_BYTE, "R9 read wait", w, 2 * PER_BYTE);
    end
    p0 = rd_ptr;
    access(0, 0, 3'h0, 0, r, w);
    check(r == {8'h00, rd_pat(p0)} && rev_cnt == 1, "R7 byte read", r, rd_pat(p0));

    // R10 ignored accesses
    set_mode(8'h00);
    access(1, 1, 3'h0, 16'hA5A5, r, w);
    check(wev_cnt == 0 && w == 0, "R10 write CE off", wev_cnt, 0);
    access(0, 1, 3'h0, 0, r, w);
    check(rev_cnt == 0 && w == 0 && r == 0, "R10 read CE off", r, 0);
    set_mode(8'h14);
    access(1, 1, 3'h0, 16'h5A5A, r, w);
    check(wev_cnt == 0 && w == 0 && nf_dq_oe == 0, "R10 write bit7 clear", wev_cnt, 0);
    p0 = rd_ptr;
    access(0, 1, 3'h0, 0, r, w);
    check(rev_cnt == 2 && r == {rd_pat(p0 + 1), rd_pat(p0)}, "R10 read allowed", r,
          {rd_pat(p0 + 1), rd_pat(p0)});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule